// File: doc/BRIEF.md
# Windowed Detector Readout Sequencer

This block walks the address space of a square pixel array and presents one pixel address per clock to a single output channel. A frame can be a plain full-field raster, a rectangular sub-window, or a guide scan. A guide scan reads one full-field row, then the whole sub-window, then the next full-field row, so a small region is sampled many times while the full frame advances one row at a time. A subsampled raster steps over rows and columns by a programmable stride.

Each address carries a flag when it lies in the reference border around the light-sensitive core. The block can also drive a reset strobe per pixel, per row, or once for the whole array before the scan. The mode, reset scope, stride and window bounds are captured when a frame is started. A window whose lower bound is above its upper bound is refused with an error flag, and no scan takes place.

Top module: `readout_seq`

## Requirements
- R1: After reset, busy, pix_valid, rst_strobe, frame_done and win_err are all 0.
- R2: In mode 0 (full field), the block presents every address once in row-major order. It starts at row 0, column 0, and presents one address per cycle with pix_valid high.
- R3: ref_pix is high exactly on valid beats whose row or column is below REF or at least N-REF.
- R4: In mode 1 (window), only addresses with col_lo..col_hi and row_lo..row_hi inclusive are presented, in row-major order. The bounds are taken from the inputs in the cycle the frame is started, and later changes have no effect.
- R5: In mode 2 (guide), each full-field row except the last is followed by the whole window. The window read leaves the full-field row pointer unchanged, and the next full-field row is the following row.
- R6: In mode 3 (subsample), only addresses whose row and column are multiples of the stride are presented, in row-major order. A stride of 0 acts as 1.
- R7: With reset scope 1 (pixel), rst_strobe is high on every full-field beat.
- R8: With reset scope 2 (line), rst_strobe is high only on the last full-field beat of each row.
- R9: With reset scope 3 (global), rst_strobe is high for exactly one cycle without pix_valid before the first beat, and on no beat.
- R10: In mode 1 or 2, a start with col_lo > col_hi or row_lo > row_hi sets win_err, leaves busy low and presents no beat. The next accepted start clears win_err.
- R11: frame_done is high for one cycle, in the cycle after the last beat. busy is low in the following cycle.
- R12: A start while busy has no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start request, accepted when idle |
| mode | input | 2 | 0 full, 1 window, 2 guide, 3 subsample |
| rst_sel | input | 2 | 0 none, 1 pixel, 2 line, 3 global |
| stride | input | SW | Subsample step |
| col_lo | input | AW | Window first column |
| col_hi | input | AW | Window last column |
| row_lo | input | AW | Window first row |
| row_hi | input | AW | Window last row |
| busy | output | 1 | Frame in progress |
| pix_valid | output | 1 | Address on row_addr/col_addr is a read beat |
| row_addr | output | AW | Row address |
| col_addr | output | AW | Column address |
| ref_pix | output | 1 | Beat lies in the reference border |
| rst_strobe | output | 1 | Reset strobe |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| win_err | output | 1 | Last start was refused for a reversed window |

## Verification
Several properties are checked on every cycle. Window beats stay within the captured bounds, and the full-field row pointer holds still during a window read. frame_done is a single pulse followed by idle, a refused window never produces a beat, the reference flag appears only on beats, and a start while busy leaves the captured mode unchanged. Only the bench's scenarios can show the exact order and count of addresses in each mode, the placement of pixel, line and global reset strobes, and the stride arithmetic. The bench compares every beat of a 16x16 array with arithmetically generated sequences.

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int N   = 2048,
  parameter int REF = 4,
  parameter int SW  = 4,
  localparam int AW = $clog2(N),
  localparam int W  = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [1:0]    rst_sel,
  input  logic [SW-1:0] stride,
  input  logic [AW-1:0] col_lo,
  input  logic [AW-1:0] col_hi,
  input  logic [AW-1:0] row_lo,
  input  logic [AW-1:0] row_hi,
  output logic          busy,
  output logic          pix_valid,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic          ref_pix,
  output logic          rst_strobe,
  output logic          frame_done,
  output logic          win_err
);
  localparam logic [1:0] M_FULL = 2'd0, M_WIN = 2'd1, M_GUIDE = 2'd2, M_SUB = 2'd3;
  localparam logic [1:0] R_PIX = 2'd1, R_LINE = 2'd2, R_ALL = 2'd3;
  localparam logic [W-1:0] LAST = W'(N - 1);

  typedef enum logic [2:0] {S_IDLE, S_GRST, S_FULL, S_WIN, S_DONE} st_t;
  st_t st;

  logic [1:0]    mode_q, rsel_q;
  logic [SW-1:0] step_q;
  logic [AW-1:0] cl_q, ch_q, rl_q, rh_q;
  logic [AW-1:0] row, col, wr, wc;

  wire bad_win = (mode == M_WIN || mode == M_GUIDE) && (col_lo > col_hi || row_lo > row_hi);
  wire [SW-1:0] step_eff = (mode_q == M_SUB) ? step_q : SW'(1);
  wire last_col = (W'(col) + W'(step_eff)) > LAST;
  wire last_row = (W'(row) + W'(step_eff)) > LAST;
  wire last_wc  = (wc == ch_q);
  wire last_wr  = (wr == rh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= '0; rsel_q <= '0; step_q <= SW'(1);
      cl_q <= '0; ch_q <= '0; rl_q <= '0; rh_q <= '0;
      row <= '0; col <= '0; wr <= '0; wc <= '0; win_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          win_err <= bad_win;
          if (!bad_win) begin
            mode_q <= mode; rsel_q <= rst_sel;
            step_q <= (stride == '0) ? SW'(1) : stride;
            cl_q <= col_lo; ch_q <= col_hi; rl_q <= row_lo; rh_q <= row_hi;
            row <= '0; col <= '0; wr <= row_lo; wc <= col_lo;
            if (rst_sel == R_ALL)   st <= S_GRST;
            else if (mode == M_WIN) st <= S_WIN;
            else                    st <= S_FULL;
          end
        end
        S_GRST: st <= (mode_q == M_WIN) ? S_WIN : S_FULL;
        S_FULL: begin
          if (!last_col) col <= col + AW'(step_eff);
          else begin
            col <= '0;
            if (last_row) st <= S_DONE;
            else begin
              row <= row + AW'(step_eff);
              if (mode_q == M_GUIDE) st <= S_WIN;
            end
          end
        end
        S_WIN: begin
          if (!last_wc) wc <= wc + 1'b1;
          else begin
            wc <= cl_q;
            if (!last_wr) wr <= wr + 1'b1;
            else begin
              wr <= rl_q;
              st <= (mode_q == M_GUIDE) ? S_FULL : S_DONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign pix_valid  = (st == S_FULL) || (st == S_WIN);
  assign row_addr   = (st == S_WIN) ? wr : row;
  assign col_addr   = (st == S_WIN) ? wc : col;
  assign frame_done = (st == S_DONE);
  assign rst_strobe = (st == S_GRST) ||
                      ((st == S_FULL) && (rsel_q == R_PIX || (rsel_q == R_LINE && last_col)));
  assign ref_pix = pix_valid &&
                   (row_addr < AW'(REF) || row_addr >= AW'(N - REF) ||
                    col_addr < AW'(REF) || col_addr >= AW'(N - REF));

  assert_win_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN) |-> (row_addr >= rl_q && row_addr <= rh_q && col_addr >= cl_q && col_addr <= ch_q));
  assert_row_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN && $past(st == S_WIN)) |-> $stable(row));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!frame_done && !busy));
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |-> !pix_valid);
  assert_ref_on_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pix |-> pix_valid);
  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_done) |=> $stable(mode_q));
endmodule

// File: tb/readout_seq_tb.sv
module readout_seq_tb;
  localparam int N = 16, REF = 2, SW = 3, AW = 4;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0, rst_sel = 0;
  logic [SW-1:0] stride = 0;
  logic [AW-1:0] col_lo = 0, col_hi = 0, row_lo = 0, row_hi = 0;
  logic busy, pix_valid, ref_pix, rst_strobe, frame_done, win_err;
  logic [AW-1:0] row_addr, col_addr;
  int tests = 0, fails = 0;
  int er[0:1023], ecol[0:1023], erst[0:1023], eref[0:1023];
  int en;

  always #2 clk = ~clk;

  readout_seq #(.N(N), .REF(REF), .SW(SW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic push(input int r, input int c, input int rs);
    er[en] = r; ecol[en] = c; erst[en] = rs;
    eref[en] = (r < REF || r >= N - REF || c < REF || c >= N - REF);
    en++;
  endtask

  task automatic build(input int m, input int rs, input int sd, input int cl, input int ch, input int rl, input int rh);
    int s;
    en = 0;
    s = (m == 3) ? ((sd == 0) ? 1 : sd) : 1;
    if (m == 1) begin
      for (int r = rl; r <= rh; r++) for (int c = cl; c <= ch; c++) push(r, c, 0);
    end else begin
      for (int r = 0; r < N; r += s) begin
        for (int c = 0; c < N; c += s) push(r, c, (rs == 1) || (rs == 2 && c + s > N - 1));
        if (m == 2 && r < N - 1)
          for (int wr = rl; wr <= rh; wr++) for (int wc = cl; wc <= ch; wc++) push(wr, wc, 0);
      end
    end
  endtask

  task automatic run(input int m, input int rs, input int sd, input int cl, input int ch,
                     input int rl, input int rh, input string req);
    int k, bad, ghost, lastv, doneat, cyc;
    build(m, rs, sd, cl, ch, rl, rh);
    mode = m[1:0]; rst_sel = rs[1:0]; stride = sd[SW-1:0];
    col_lo = cl[AW-1:0]; col_hi = ch[AW-1:0]; row_lo = rl[AW-1:0]; row_hi = rh[AW-1:0];
    start = 1;
    @(negedge clk);
    start = 0;
    col_lo = 0; col_hi = N - 1; row_lo = 0; row_hi = N - 1;
    k = 0; bad = -1; ghost = 0; lastv = -5; doneat = -1; cyc = 0;
    while (cyc < 20000) begin
      if (pix_valid) begin
        if (k < en && bad < 0 &&
            (row_addr != er[k] || col_addr != ecol[k] || rst_strobe != erst[k] || ref_pix != eref[k]))
          bad = k;
        k++; lastv = cyc;
      end else if (rst_strobe) ghost++;
      if (frame_done) begin doneat = cyc; break; end
      if (cyc == 20) begin start = 1; mode = 2'd1; rst_sel = 2'd3; end
      else start = 0;
      cyc++;
      @(negedge clk);
    end
    start = 0;
    chk(k == en, {req, " beat count"}, k, en);
    chk(bad < 0, {req, " beat order/rst/ref R3 R12"}, bad, -1);
    chk(doneat == lastv + 1, {req, " done timing R11"}, doneat, lastv + 1);
    chk(ghost == ((rs == 3) ? 1 : 0), {req, " idle reset strobes R9"}, ghost, (rs == 3) ? 1 : 0);
    @(negedge clk);
    chk(!busy && !frame_done, {req, " idle after done R11"}, busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !pix_valid && !rst_strobe && !frame_done && !win_err, "R1 reset state",
        {busy, pix_valid, rst_strobe, frame_done, win_err}, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 0, 0, 0, 0, 0, 0, "R2 full");
    run(0, 1, 0, 0, 0, 0, 0, "R7 pixel reset");
    run(0, 2, 0, 0, 0, 0, 0, "R8 line reset");
    run(0, 3, 0, 0, 0, 0, 0, "R9 global reset");
    run(1, 0, 0, 3, 9, 5, 7, "R4 window");
    run(1, 0, 0, 15, 15, 15, 15, "R4 corner window");
    run(1, 3, 0, 0, 15, 0, 15, "R4 whole-array window");
    run(2, 0, 0, 6, 8, 6, 8, "R5 guide");
    run(2, 2, 0, 1, 1, 14, 14, "R5 guide line reset");
    run(3, 0, 3, 0, 0, 0, 0, "R6 stride 3");
    run(3, 1, 5, 0, 0, 0, 0, "R6 stride 5");
    run(3, 0, 0, 0, 0, 0, 0, "R6 stride 0");
    mode = 2'd1; col_lo = 5; col_hi = 4; row_lo = 0; row_hi = 3; start = 1;
    @(negedge clk);
    start = 0;
    chk(win_err && !busy && !pix_valid, "R10 reversed window refused", {win_err, busy, pix_valid}, 3'b100);
    repeat (3) @(negedge clk);
    chk(!pix_valid && !busy, "R10 no scan", pix_valid, 0);
    mode = 2'd2; col_lo = 2; col_hi = 3; row_lo = 4; row_hi = 2; start = 1;
    @(negedge clk);
    start = 0;
    chk(win_err && !busy, "R10 reversed rows refused", win_err, 1);
    run(0, 0, 0, 0, 0, 0, 0, "R10 clear by good start");
    chk(!win_err, "R10 err cleared", win_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule